// File: doc/BRIEF.md
# Per-Channel Cell Admission Controller

This block sits on the receive side of a cell-based virtual-channel reassembly engine. For each arriving cell it decides whether the cell is written into a host buffer or thrown away. When a packet begins on a channel that holds no buffer, the block asks the free-buffer source for one in the same cycle. If the buffer is refused, the cell is dropped.

Framed channels (two packet-adaptation formats) count accepted cells against a programmed buffer length. A cell that would exceed that length is reported as an overflow, and the rest of the packet is discarded. An optional per-channel wait setting makes a refused first cell discard the whole packet, up to and including its end-of-packet cell. Raw-cell channels have no end-of-packet marker. Each packet on them is a fixed number of cells, and a two's-complement length counter closes it when the counter wraps to zero.

Per-channel state lives in a small register file indexed by channel number. This lets packets on different channels interleave freely, one cell at a time.

Top module: `rx_cell_admit`

## Requirements
- R1: After reset every channel holds no buffer and is not discarding, and `buf_req`, `cell_acc`, `cell_drop`, `pkt_done` and `buf_ovf` are all 0.
- R2: `cell_mode` is encoded as 0 = framed format A, 1 = framed format B, 2 = raw cell, 3 = maintenance cell. A valid cell on a channel that holds no buffer and is not discarding raises `buf_req` in the same cycle. If `buf_gnt` is 1 in that cycle, the cell is accepted. Every valid cell gets exactly one verdict, accept or drop.
- R3: A first cell whose request sees `buf_gnt` = 0 is dropped. With the wait setting off, the next cell on that channel is again a first cell and requests a buffer.
- R4: In modes 0 and 1 with `chan_wait_en` = 1, a refused first cell that is not end-of-packet puts the channel into discard. Later cells are then dropped without a request, including the end-of-packet cell. The cell after that is a new first cell.
- R5: In modes 2 and 3, `chan_wait_en` has no effect: after a refused first cell, the next cell requests a buffer again.
- R6: In modes 0, 1 and 3, an accepted end-of-packet cell raises `pkt_done` and releases the buffer. The next cell on that channel requests a new buffer.
- R7: In modes 0, 1 and 3, a cell that would make the accepted count of the packet exceed `chan_len` is dropped with a one-cycle `buf_ovf` and no `pkt_done`. The buffer is released, and later cells are dropped without a request up to and including end-of-packet.
- R8: In mode 2, `chan_len` holds minus the packet size in cells, as an 11-bit two's-complement value (0x7FF means one cell). The counter starts at `chan_len` + 1 on the first cell and adds one per accepted cell. The cell on which it wraps to zero raises `pkt_done`. `cell_eop` is ignored in this mode.
- R9: State is kept per channel, so cells of one channel do not change the verdicts of another channel.
- R10: Verdict outputs and `res_ch` appear on the clock edge after the cell. A cycle with no valid cell gives all verdict outputs 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_vld | input | 1 | A cell is present this cycle |
| cell_ch | input | CH_W | Channel number of the cell |
| cell_eop | input | 1 | Cell is the last of its packet (framed modes) |
| cell_mode | input | 2 | Channel mode: 0/1 framed, 2 raw, 3 maintenance |
| chan_wait_en | input | 1 | Channel wait-on-refusal setting |
| chan_len | input | LEN_W | Buffer size in cells, or negated raw packet size |
| buf_req | output | 1 | Request for a free buffer (combinational) |
| buf_gnt | input | 1 | Free buffer available, same cycle as request |
| cell_acc | output | 1 | Previous cell accepted into the buffer |
| cell_drop | output | 1 | Previous cell discarded |
| pkt_done | output | 1 | Previous cell completed its packet |
| buf_ovf | output | 1 | Previous cell overflowed the buffer |
| res_ch | output | CH_W | Channel of the previous cell (0 when none) |

## Verification
The hardest situation to reach from the ports is a discarding channel that is offered granted buffers: the wait or overflow discard must keep it from asking for a buffer or taking one. The stimulus gets there in two ways. It refuses the grant exactly on a first cell with the wait setting on. It also runs a framed packet one cell past its programmed length. In both cases it then holds `buf_gnt` high through the rest of the packet, and interleaves other channels between the cells. A pseudo-random phase then mixes all four modes, with random grants, end-of-packet marks and idle cycles, against the reference model.

// File: rtl/rca_pkg.sv
package rca_pkg;

   typedef enum logic [1:0] {
      MODE_FRM_A = 2'd0,
      MODE_FRM_B = 2'd1,
      MODE_RAW   = 2'd2,
      MODE_MAINT = 2'd3
   } rca_mode_e;

   typedef struct packed {
      logic held;   // a buffer is owned by the packet in progress
      logic skip;   // discarding until end of packet
   } rca_flags_t;

endpackage

// File: rtl/rca_ctx_file.sv
module rca_ctx_file
   import rca_pkg::*;
#(
   parameter int CH_W  = 3,
   parameter int LEN_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CH_W-1:0]  rd_ch,
   output rca_flags_t       rd_flags,
   output logic [LEN_W-1:0] rd_cnt,
   input  logic             wr_en,
   input  logic [CH_W-1:0]  wr_ch,
   input  rca_flags_t       wr_flags,
   input  logic [LEN_W-1:0] wr_cnt
);
   localparam int NCH = 1 << CH_W;

   rca_flags_t       flags_vec [NCH];
   logic [LEN_W-1:0] cnt_vec   [NCH];

   for (genvar g = 0; g < NCH; g++) begin : g_chan
      rca_flags_t       f_q;
      logic [LEN_W-1:0] c_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            f_q <= '0;
            c_q <= '0;
         end else if (wr_en && (wr_ch == CH_W'(g))) begin
            f_q <= wr_flags;
            c_q <= wr_cnt;
         end
      end
      assign flags_vec[g] = f_q;
      assign cnt_vec[g]   = c_q;
   end

   assign rd_flags = flags_vec[rd_ch];
   assign rd_cnt   = cnt_vec[rd_ch];
endmodule

// File: rtl/rca_decide.sv
module rca_decide
   import rca_pkg::*;
#(
   parameter int LEN_W = 11
) (
   input  logic             vld,
   input  logic             eop,
   input  rca_mode_e        mode,
   input  logic             wait_en,
   input  logic [LEN_W-1:0] len,
   input  logic             gnt,
   input  rca_flags_t       flags,
   input  logic [LEN_W-1:0] cnt,
   output logic             req,
   output logic             acc,
   output logic             drop,
   output logic             done,
   output logic             ovf,
   output rca_flags_t       nflags,
   output logic [LEN_W-1:0] ncnt
);
   localparam logic [LEN_W:0]   ONE_W = (LEN_W+1)'(1);
   localparam logic [LEN_W-1:0] ONE   = LEN_W'(1);

   logic             wait_eff;
   logic [LEN_W:0]   frm_next;
   logic [LEN_W-1:0] raw_next;

   // wait setting only honoured on the two framed formats
   assign wait_eff = wait_en && (mode == MODE_FRM_A || mode == MODE_FRM_B);
   assign frm_next = flags.held ? ({1'b0, cnt} + ONE_W) : ONE_W;
   assign raw_next = flags.held ? (cnt + ONE) : (len + ONE);

   always_comb begin
      req    = 1'b0;
      acc    = 1'b0;
      drop   = 1'b0;
      done   = 1'b0;
      ovf    = 1'b0;
      nflags = flags;
      ncnt   = cnt;
      if (vld) begin
         if (mode == MODE_RAW) begin
            nflags.skip = 1'b0;
            req = !flags.held;
            if (flags.held || gnt) begin
               acc  = 1'b1;
               ncnt = raw_next;
               if (raw_next == '0) begin
                  done        = 1'b1;
                  nflags.held = 1'b0;
               end else begin
                  nflags.held = 1'b1;
               end
            end else begin
               drop = 1'b1;
            end
         end else if (flags.skip) begin
            drop = 1'b1;
            if (eop) nflags.skip = 1'b0;
         end else begin
            req = !flags.held;
            if (!flags.held && !gnt) begin
               drop        = 1'b1;
               nflags.skip = wait_eff && !eop;
            end else if (frm_next > {1'b0, len}) begin
               drop        = 1'b1;
               ovf         = 1'b1;
               nflags.held = 1'b0;
               nflags.skip = !eop;
            end else begin
               acc  = 1'b1;
               ncnt = frm_next[LEN_W-1:0];
               if (eop) begin
                  done        = 1'b1;
                  nflags.held = 1'b0;
               end else begin
                  nflags.held = 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/rx_cell_admit.sv
module rx_cell_admit
   import rca_pkg::*;
#(
   parameter int CH_W  = 3,
   parameter int LEN_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cell_vld,
   input  logic [CH_W-1:0]  cell_ch,
   input  logic             cell_eop,
   input  logic [1:0]       cell_mode,
   input  logic             chan_wait_en,
   input  logic [LEN_W-1:0] chan_len,
   output logic             buf_req,
   input  logic             buf_gnt,
   output logic             cell_acc,
   output logic             cell_drop,
   output logic             pkt_done,
   output logic             buf_ovf,
   output logic [CH_W-1:0]  res_ch
);
   if (CH_W < 1 || CH_W > 8) begin : g_bad_ch
      $error("rx_cell_admit: CH_W must be 1..8");
   end
   if (LEN_W < 2 || LEN_W > 16) begin : g_bad_len
      $error("rx_cell_admit: LEN_W must be 2..16");
   end

   rca_flags_t       cur_flags, nxt_flags;
   logic [LEN_W-1:0] cur_cnt, nxt_cnt;
   logic             d_acc, d_drop, d_done, d_ovf;

   rca_ctx_file #(.CH_W(CH_W), .LEN_W(LEN_W)) u_ctx (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_ch    (cell_ch),
      .rd_flags (cur_flags),
      .rd_cnt   (cur_cnt),
      .wr_en    (cell_vld),
      .wr_ch    (cell_ch),
      .wr_flags (nxt_flags),
      .wr_cnt   (nxt_cnt)
   );

   rca_decide #(.LEN_W(LEN_W)) u_dec (
      .vld     (cell_vld),
      .eop     (cell_eop),
      .mode    (rca_mode_e'(cell_mode)),
      .wait_en (chan_wait_en),
      .len     (chan_len),
      .gnt     (buf_gnt),
      .flags   (cur_flags),
      .cnt     (cur_cnt),
      .req     (buf_req),
      .acc     (d_acc),
      .drop    (d_drop),
      .done    (d_done),
      .ovf     (d_ovf),
      .nflags  (nxt_flags),
      .ncnt    (nxt_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cell_acc  <= 1'b0;
         cell_drop <= 1'b0;
         pkt_done  <= 1'b0;
         buf_ovf   <= 1'b0;
         res_ch    <= '0;
      end else begin
         cell_acc  <= d_acc;
         cell_drop <= d_drop;
         pkt_done  <= d_done;
         buf_ovf   <= d_ovf;
         res_ch    <= cell_vld ? cell_ch : '0;
      end
   end
endmodule

// File: rtl/rca_chk.sv
module rca_chk (
   input logic clk,
   input logic rst_n,
   input logic cell_vld,
   input logic buf_req,
   input logic buf_gnt,
   input logic cell_acc,
   input logic cell_drop,
   input logic pkt_done,
   input logic buf_ovf
);
   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cell_vld |=> !(cell_acc || cell_drop || pkt_done || buf_ovf));

   // R2
   one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cell_vld |=> (cell_acc ^ cell_drop));

   // R2
   req_with_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_req |-> cell_vld);

   // R3
   refused_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_req && !buf_gnt) |=> cell_drop);

   // R6
   done_accepted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_done |-> cell_acc);

   // R7
   ovf_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_ovf |-> (cell_drop && !pkt_done));
endmodule

bind rx_cell_admit rca_chk u_rca_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cell_vld  (cell_vld),
   .buf_req   (buf_req),
   .buf_gnt   (buf_gnt),
   .cell_acc  (cell_acc),
   .cell_drop (cell_drop),
   .pkt_done  (pkt_done),
   .buf_ovf   (buf_ovf)
);

// File: tb/test_rx_cell_admit.sv
module test_rx_cell_admit;
   localparam int CH_W  = 3;
   localparam int LEN_W = 11;
   localparam int NCH   = 1 << CH_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cell_vld = 1'b0;
   logic [CH_W-1:0]  cell_ch = '0;
   logic             cell_eop = 1'b0;
   logic [1:0]       cell_mode = 2'd0;
   logic             chan_wait_en = 1'b0;
   logic [LEN_W-1:0] chan_len = '0;
   logic             buf_gnt = 1'b0;
   logic             buf_req, cell_acc, cell_drop, pkt_done, buf_ovf;
   logic [CH_W-1:0]  res_ch;

   always #10 clk = ~clk;   // 50 MHz

   rx_cell_admit #(.CH_W(CH_W), .LEN_W(LEN_W)) i_rx_cell_admit (
      .clk(clk), .rst_n(rst_n), .cell_vld(cell_vld), .cell_ch(cell_ch),
      .cell_eop(cell_eop), .cell_mode(cell_mode), .chan_wait_en(chan_wait_en),
      .chan_len(chan_len), .buf_req(buf_req), .buf_gnt(buf_gnt),
      .cell_acc(cell_acc), .cell_drop(cell_drop), .pkt_done(pkt_done),
      .buf_ovf(buf_ovf), .res_ch(res_ch)
   );

   int checks = 0;
   int failures = 0;
   string tag = "R1";

   // reference state per channel
   bit m_held [NCH];
   bit m_skip [NCH];
   int m_cnt  [NCH];
   // expected registered outputs
   bit e_acc = 0, e_drop = 0, e_done = 0, e_ovf = 0;
   int e_ch = 0;

   task automatic check(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic step(input bit v, input int ch, input int md, input bit w,
                       input int len, input bit eop, input bit g);
      bit req;
      int n;
      @(negedge clk);
      check(cell_acc  == e_acc,  "cell_acc",  int'(cell_acc),  int'(e_acc));
      check(cell_drop == e_drop, "cell_drop", int'(cell_drop), int'(e_drop));
      check(pkt_done  == e_done, "pkt_done",  int'(pkt_done),  int'(e_done));
      check(buf_ovf   == e_ovf,  "buf_ovf",   int'(buf_ovf),   int'(e_ovf));
      check(int'(res_ch) == e_ch, "res_ch",   int'(res_ch),    e_ch);
      cell_vld     = v;
      cell_ch      = CH_W'(ch);
      cell_mode    = 2'(md);
      chan_wait_en = w;
      chan_len     = LEN_W'(len);
      cell_eop     = eop;
      buf_gnt      = g;
      #1;
      req = 0; e_acc = 0; e_drop = 0; e_done = 0; e_ovf = 0;
      e_ch = v ? ch : 0;
      if (v) begin
         if (md == 2) begin
            m_skip[ch] = 0;
            if (m_held[ch]) begin
               m_cnt[ch] = (m_cnt[ch] + 1) % 2048;
               e_acc = 1;
               if (m_cnt[ch] == 0) begin e_done = 1; m_held[ch] = 0; end
            end else begin
               req = 1;
               if (g) begin
                  e_acc = 1;
                  m_cnt[ch] = (len + 1) % 2048;
                  if (m_cnt[ch] == 0) e_done = 1; else m_held[ch] = 1;
               end else e_drop = 1;
            end
         end else if (m_skip[ch]) begin
            e_drop = 1;
            if (eop) m_skip[ch] = 0;
         end else if (!m_held[ch] && !g) begin
            req = 1;
            e_drop = 1;
            m_skip[ch] = w && (md < 2) && !eop;
         end else begin
            req = !m_held[ch];
            n = m_held[ch] ? m_cnt[ch] + 1 : 1;
            if (n > len) begin
               e_drop = 1; e_ovf = 1; m_held[ch] = 0; m_skip[ch] = !eop;
            end else begin
               e_acc = 1; m_cnt[ch] = n;
               if (eop) begin e_done = 1; m_held[ch] = 0; end
               else m_held[ch] = 1;
            end
         end
      end
      check(buf_req == req, "buf_req", int'(buf_req), int'(req));
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, 0);
   endtask

   int seed = 32'h1d2c3b4a;
   function automatic int rnd(input int modv);
      seed = seed * 1103515245 + 12345;
      return ((seed >>> 8) & 32'h7fffff) % modv;
   endfunction

   initial begin
      #200000000;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int wset [NCH];
      int lset [NCH];
      for (int i = 0; i < NCH; i++) begin m_held[i] = 0; m_skip[i] = 0; m_cnt[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: outputs quiet after reset
      tag = "R1"; idle(); idle();

      // R2, R6: framed A, length 4, three-cell packet completes
      tag = "R2"; step(1, 0, 0, 0, 4, 0, 1);
      tag = "R6"; step(1, 0, 0, 0, 4, 0, 1); step(1, 0, 0, 0, 4, 1, 1);
      step(1, 0, 0, 0, 4, 1, 1);  // single-cell packet, fresh request

      // R3: refusal without wait, next cell requests again
      tag = "R3"; step(1, 1, 0, 0, 4, 0, 0); step(1, 1, 0, 0, 4, 0, 1);
      step(1, 1, 0, 0, 4, 1, 1);

      // R4: wait mode on framed B, grants offered during discard
      tag = "R4"; step(1, 2, 1, 1, 4, 0, 0);
      step(1, 2, 1, 1, 4, 0, 1); idle();
      step(1, 0, 0, 0, 4, 1, 1);   // another channel interleaved
      step(1, 2, 1, 1, 4, 0, 1); step(1, 2, 1, 1, 4, 1, 1);
      step(1, 2, 1, 1, 4, 1, 1);   // new first cell after end

      // R5: wait ignored on raw and maintenance channels
      tag = "R5"; step(1, 3, 2, 1, 'h7FF, 0, 0); step(1, 3, 2, 1, 'h7FF, 0, 1);
      step(1, 4, 3, 1, 4, 0, 0); step(1, 4, 3, 1, 4, 1, 1);

      // R8: raw three-cell packets, end marks ignored
      tag = "R8"; step(1, 3, 2, 0, 'h7FD, 1, 1); step(1, 3, 2, 0, 'h7FD, 1, 0);
      step(1, 3, 2, 0, 'h7FD, 0, 0); step(1, 3, 2, 0, 'h7FD, 0, 1);
      step(1, 3, 2, 0, 'h7FF, 0, 1);

      // R7: framed B length 2 overflows on third cell
      tag = "R7"; step(1, 5, 1, 0, 2, 0, 1); step(1, 5, 1, 0, 2, 0, 1);
      step(1, 5, 1, 0, 2, 0, 1); step(1, 5, 1, 0, 2, 0, 1);
      step(1, 5, 1, 0, 2, 1, 1); step(1, 5, 1, 0, 2, 1, 1);
      // overflow on an end cell clears at once (maintenance mode)
      step(1, 6, 3, 0, 1, 0, 1); step(1, 6, 3, 0, 1, 1, 1); step(1, 6, 3, 0, 1, 1, 1);

      // R10: idle gap after traffic
      tag = "R10"; idle(); idle();

      // R9: random interleaving, each channel keeps its mode and length
      tag = "R9";
      for (int c = 0; c < NCH; c++) begin
         wset[c] = rnd(2);
         lset[c] = (c % 4 == 2) ? (2048 - 1 - rnd(3)) : (2 + rnd(4));
      end
      for (int k = 0; k < 600; k++) begin
         int c;
         c = rnd(NCH);
         if (rnd(5) == 0) idle();
         else step(1, c, c % 4, wset[c][0], lset[c], rnd(10) < 3, rnd(10) < 7);
      end
      idle(); idle();

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule